// File: doc/BRIEF.md
# Multi-Channel Compare Timer

This block is a 64-bit up-counter shared by several 64-bit compare channels. The counter steps once per tick, and a prescaler with a power-of-two divider sets the tick rate as a fraction of the clock. Each channel has its own enable. When the counter steps onto a channel's value, that channel latches a pending status bit. If the channel is set to repeat, it also adds its 32-bit increment to its compare value. Every channel drives its own interrupt line. The line is high while the channel's status bit is pending and its interrupt enable is set.

Software uses one 32-bit register port with a write strobe and a combinational read path. Each 64-bit value is split into a low word and a high word. Each register write is recorded in sticky acknowledge flags, and software clears these flags by writing ones. A typical use is periodic events at different rates from one time base. Software loads a start compare value and an increment, enables repeat on the channel, and acknowledges each interrupt by writing its status bit.

Top module: `gtmr_timer`

## Requirements
- R1: After reset the counter, every compare value, every increment, the configuration, control, status, interrupt-enable and both acknowledge registers read zero, and every irq line is low.
- R2: The configuration register at 0x000 holds the prescaler P in bits 7:0 and the divider exponent D in bits 10:8. While running, the counter advances once every (P+1)*2^D clock cycles, and writing the configuration restarts the division.
- R3: The counter advances only while control bit 8 (0x240) is set. While that bit is clear the counter holds its value.
- R4: The counter is read and written as a low word at 0x100 and a high word at 0x104. A write replaces only that word and takes precedence over a step in the same cycle. A step carries from the low word into the high word.
- R5: Channel i (0..3) has its low word at 0x200+0x10*i, its high word at 0x204+0x10*i and its increment at 0x208+0x10*i. Each reads back what was written.
- R6: When the counter steps onto the value of a channel whose control bit 2i is set, status bit i at 0x244 becomes 1. A channel whose bit 2i is clear never sets its status.
- R7: When control bit 2i+1 is set, a match on channel i adds the channel's increment to its compare value in the same cycle.
- R8: irq[i] is high exactly when status bit i and bit i of the enable register at 0x248 are both 1. Setting the enable while status is pending raises the line in the cycle after the write.
- R9: Writing a 1 to bit i of 0x244 clears status bit i and drops irq[i]. Bits written with 0 are unchanged.
- R10: At 0x110, bit 0 is set by a counter low-word write and bit 1 by a counter high-word write. Both bits are sticky and are cleared by writing ones to them.
- R11: At 0x24C, channel i's low-word write sets bit 4i, its high-word write sets bit 4i+1 and its increment write sets bit 4i+2. A control write sets bit 16. All these bits are sticky and are cleared by writing ones to them.
- R12: Reads from unmapped offsets return zero, and writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | NUM_CH (4) | Per-channel interrupt lines |

## Verification
The embedded assertions check on every cycle that:
- the counter holds while stopped and moves by exactly one per step;
- the divider phase stays inside the programmed period;
- a match sets status and applies the increment;
- status rises only on a match, and a clear without a match removes it;
- acknowledge flags never fall unless their register is written.

Some behaviours can only be shown by the bench's scenarios:
- the absolute tick rate for a given prescaler and divider;
- the exact cycle of a match after a carry across the word boundary;
- interrupt gating and raising an interrupt that is already pending;
- the bit positions of the acknowledge flags;
- the silence of unmapped offsets.

A cycle-by-cycle reference model drives randomized rounds with mixed channel enables and repeat settings. It is compared against the irq lines on every cycle and against the final compare values.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam int ADDR_W = 12;
  localparam int WORD_W = 32;
  localparam int TIME_W = 2 * WORD_W;
  localparam int PRE_W  = 8;
  localparam int DIV_W  = 3;
  localparam int CFG_W  = PRE_W + DIV_W;
  localparam int RUN_BIT = 8;
  localparam int WST_W  = 17;

  localparam logic [ADDR_W-1:0] OFS_CFG     = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO  = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI  = 12'h104;
  localparam logic [ADDR_W-1:0] OFS_CNT_ACK = 12'h110;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 12'h240;
  localparam logic [ADDR_W-1:0] OFS_STAT    = 12'h244;
  localparam logic [ADDR_W-1:0] OFS_IEN     = 12'h248;
  localparam logic [ADDR_W-1:0] OFS_ACK     = 12'h24C;
  localparam logic [ADDR_W-1:0] OFS_CH_BASE = 12'h200;

  // k: 0 low word, 1 high word, 2 increment
  function automatic logic [ADDR_W-1:0] ch_ofs(input int ch, input int k);
    return OFS_CH_BASE + ADDR_W'(16 * ch + 4 * k);
  endfunction

  function automatic logic [TIME_W-1:0] put_word(input logic [TIME_W-1:0] v,
                                                 input logic hi,
                                                 input logic [WORD_W-1:0] w);
    return hi ? {w, v[WORD_W-1:0]} : {v[TIME_W-1:WORD_W], w};
  endfunction
endpackage

// File: rtl/gtmr_tick_gen.sv
module gtmr_tick_gen #(
  parameter int PRE_W = 8,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre,
  input  logic [DIV_W-1:0] dsel,
  output logic             tick
);
  localparam int PER_W = PRE_W + (1 << DIV_W);

  function automatic logic [PER_W-1:0] period_of(input logic [PRE_W-1:0] p,
                                                 input logic [DIV_W-1:0] d);
    return (PER_W'(p) + PER_W'(1)) << d;
  endfunction

  logic [PER_W-1:0] phase_q;
  logic [PER_W-1:0] period;

  assign period = period_of(pre, dsel);
  assign tick   = (phase_q == period - PER_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase_q <= '0;
    else if (restart || tick) phase_q <= '0;
    else                     phase_q <= phase_q + PER_W'(1);
  end

  // R2: the phase never leaves the programmed period
  a_r2_phase_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < period);
endmodule

// File: rtl/gtmr_cmp_ch.sv
module gtmr_cmp_ch
  import gtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_inc,
  input  logic [WORD_W-1:0] wdata,
  input  logic              step,
  input  logic [TIME_W-1:0] next_cnt,
  input  logic              cmp_en,
  input  logic              auto_en,
  input  logic              stat_clr,
  output logic [TIME_W-1:0] cmp_val,
  output logic [WORD_W-1:0] inc_val,
  output logic              stat,
  output logic              match
);
  logic [TIME_W-1:0] cmp_q;
  logic [WORD_W-1:0] inc_q;
  logic              stat_q;

  assign match   = step && cmp_en && (next_cnt == cmp_q);
  assign cmp_val = cmp_q;
  assign inc_val = inc_q;
  assign stat    = stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      inc_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      if (wr_lo)                cmp_q <= put_word(cmp_q, 1'b0, wdata);
      else if (wr_hi)           cmp_q <= put_word(cmp_q, 1'b1, wdata);
      else if (match && auto_en) cmp_q <= cmp_q + TIME_W'(inc_q);
      if (wr_inc) inc_q <= wdata;
      if (match)         stat_q <= 1'b1;
      else if (stat_clr) stat_q <= 1'b0;
    end
  end

  // R6: a match leaves the status pending
  a_r6_match_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> stat_q);
  // R6: status rises only because of a match
  a_r6_rise_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> $past(match));
  // R7: repeat mode adds the increment on a match
  a_r7_auto_add: assert property (@(posedge clk) disable iff (!rst_n)
    (match && auto_en && !wr_lo && !wr_hi) |=> cmp_q == $past(cmp_q) + TIME_W'($past(inc_q)));
  // R9: a clear without a match removes the status
  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !match) |=> !stat_q);
endmodule

// File: rtl/gtmr_timer.sv
module gtmr_timer
  import gtmr_pkg::*;
#(
  parameter int NUM_CH = 4  // 1..4: channel offsets and ack bits fit four
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] irq
);
  logic [CFG_W-1:0]  cfg_q;
  logic [TIME_W-1:0] cnt_q;
  logic [RUN_BIT:0]  ctrl_q;
  logic [NUM_CH-1:0] ien_q;
  logic [1:0]        cnt_ack_q;
  logic [WST_W-1:0]  ack_q;

  logic wr_cfg, wr_cnt_lo, wr_cnt_hi, wr_cnt_ack, wr_ctrl, wr_stat, wr_ien, wr_ack;
  assign wr_cfg     = reg_wr && reg_addr == OFS_CFG;
  assign wr_cnt_lo  = reg_wr && reg_addr == OFS_CNT_LO;
  assign wr_cnt_hi  = reg_wr && reg_addr == OFS_CNT_HI;
  assign wr_cnt_ack = reg_wr && reg_addr == OFS_CNT_ACK;
  assign wr_ctrl    = reg_wr && reg_addr == OFS_CTRL;
  assign wr_stat    = reg_wr && reg_addr == OFS_STAT;
  assign wr_ien     = reg_wr && reg_addr == OFS_IEN;
  assign wr_ack     = reg_wr && reg_addr == OFS_ACK;

  // internal events, named for the assertions
  logic              tick, step, cnt_written;
  logic [TIME_W-1:0] next_cnt;
  assign cnt_written = wr_cnt_lo || wr_cnt_hi;
  assign step        = ctrl_q[RUN_BIT] && tick && !cnt_written;
  assign next_cnt    = cnt_q + TIME_W'(1);

  gtmr_tick_gen #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(wr_cfg),
    .pre(cfg_q[PRE_W-1:0]), .dsel(cfg_q[CFG_W-1:PRE_W]), .tick(tick)
  );

  logic [TIME_W-1:0] cmp_val [NUM_CH];
  logic [WORD_W-1:0] inc_val [NUM_CH];
  logic [NUM_CH-1:0] stat, match, ch_wr_lo, ch_wr_hi, ch_wr_inc;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_wr_lo[i]  = reg_wr && reg_addr == ch_ofs(i, 0);
    assign ch_wr_hi[i]  = reg_wr && reg_addr == ch_ofs(i, 1);
    assign ch_wr_inc[i] = reg_wr && reg_addr == ch_ofs(i, 2);
    gtmr_cmp_ch u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_lo(ch_wr_lo[i]), .wr_hi(ch_wr_hi[i]), .wr_inc(ch_wr_inc[i]),
      .wdata(reg_wdata), .step(step), .next_cnt(next_cnt),
      .cmp_en(ctrl_q[2*i]), .auto_en(ctrl_q[2*i+1]),
      .stat_clr(wr_stat && reg_wdata[i]),
      .cmp_val(cmp_val[i]), .inc_val(inc_val[i]),
      .stat(stat[i]), .match(match[i])
    );
  end

  logic [WST_W-1:0] ack_set;
  always_comb begin
    ack_set = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      ack_set[4*i]   = ch_wr_lo[i];
      ack_set[4*i+1] = ch_wr_hi[i];
      ack_set[4*i+2] = ch_wr_inc[i];
    end
    ack_set[WST_W-1] = wr_ctrl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      cnt_q     <= '0;
      ctrl_q    <= '0;
      ien_q     <= '0;
      cnt_ack_q <= '0;
      ack_q     <= '0;
    end else begin
      if (wr_cfg)    cfg_q  <= reg_wdata[CFG_W-1:0];
      if (wr_ctrl)   ctrl_q <= reg_wdata[RUN_BIT:0];
      if (wr_ien)    ien_q  <= reg_wdata[NUM_CH-1:0];
      if (wr_cnt_lo)      cnt_q <= put_word(cnt_q, 1'b0, reg_wdata);
      else if (wr_cnt_hi) cnt_q <= put_word(cnt_q, 1'b1, reg_wdata);
      else if (step)      cnt_q <= next_cnt;
      cnt_ack_q <= (cnt_ack_q & ~(wr_cnt_ack ? reg_wdata[1:0] : 2'b00))
                   | {wr_cnt_hi, wr_cnt_lo};
      ack_q <= (ack_q & ~(wr_ack ? reg_wdata[WST_W-1:0] : '0)) | ack_set;
    end
  end

  assign irq = stat & ien_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CFG:     reg_rdata = WORD_W'(cfg_q);
      OFS_CNT_LO:  reg_rdata = cnt_q[WORD_W-1:0];
      OFS_CNT_HI:  reg_rdata = cnt_q[TIME_W-1:WORD_W];
      OFS_CNT_ACK: reg_rdata = WORD_W'(cnt_ack_q);
      OFS_CTRL:    reg_rdata = WORD_W'(ctrl_q);
      OFS_STAT:    reg_rdata = WORD_W'(stat);
      OFS_IEN:     reg_rdata = WORD_W'(ien_q);
      OFS_ACK:     reg_rdata = WORD_W'(ack_q);
      default:     ;
    endcase
    for (int i = 0; i < NUM_CH; i++) begin
      if (reg_addr == ch_ofs(i, 0)) reg_rdata = cmp_val[i][WORD_W-1:0];
      if (reg_addr == ch_ofs(i, 1)) reg_rdata = cmp_val[i][TIME_W-1:WORD_W];
      if (reg_addr == ch_ofs(i, 2)) reg_rdata = inc_val[i];
    end
  end

  // R3: a stopped, unwritten counter keeps its value
  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[RUN_BIT] && !cnt_written) |=> cnt_q == $past(cnt_q));
  // R2: a step moves the counter by exactly one
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt_q == $past(cnt_q) + TIME_W'(1));
  // R10: counter acknowledge flags only fall through their own register
  a_r10_cnt_ack_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt_ack |=> (cnt_ack_q & $past(cnt_ack_q)) == $past(cnt_ack_q));
  // R11: write acknowledge flags only fall through their own register
  a_r11_ack_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ack |=> (ack_q & $past(ack_q)) == $past(ack_q));
endmodule

// File: tb/tb_gtmr_timer.sv
module tb_gtmr_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NCH-1:0] irq;

  int checks = 0;
  int errors = 0;

  gtmr_timer #(.NUM_CH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] ofs(input int ch, input int k);
    return 12'h200 + 12'(ch * 16 + k * 4);
  endfunction

  function automatic logic [31:0] ticks_in(input int cycles, input int pre, input int dexp);
    return 32'(cycles / ((pre + 1) * (1 << dexp)));
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic rd64(input logic [11:0] a, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(a, lo); rd(a + 12'h4, hi);
    v = {hi, lo};
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=completion");
    summary();
    $finish;
  end

  // reference model state
  logic [63:0] m_cnt;
  logic [63:0] m_cmp [NCH];
  logic [31:0] m_inc [NCH];
  logic [NCH-1:0] m_en, m_auto, m_stat;

  task automatic model_step;
    m_cnt = m_cnt + 64'd1;
    for (int c = 0; c < NCH; c++)
      if (m_en[c] && m_cnt == m_cmp[c]) begin
        m_stat[c] = 1'b1;
        if (m_auto[c]) m_cmp[c] = m_cmp[c] + 64'(m_inc[c]);
      end
  endtask

  initial begin
    logic [31:0] v, v2;
    logic [63:0] w;
    logic [31:0] ctrl;
    int mism;
    void'($urandom(32'd20240611));

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 irq", 64'(irq), 64'h0);
    foreach (v[i]) ;
    begin
      logic [11:0] regs [8] = '{12'h000, 12'h100, 12'h104, 12'h110,
                               12'h240, 12'h244, 12'h248, 12'h24C};
      for (int i = 0; i < 8; i++) begin rd(regs[i], v); chk("R1 reg", 64'(v), 64'h0); end
      for (int c = 0; c < NCH; c++)
        for (int k = 0; k < 3; k++) begin rd(ofs(c, k), v); chk("R1 channel", 64'(v), 64'h0); end
    end

    // R3: stopped counter holds
    rd(12'h100, v); repeat (20) @(posedge clk); #1; rd(12'h100, v2);
    chk("R3 hold", 64'(v2), 64'(v));

    // R2: tick rates (phase independent count over a whole number of periods)
    wr(12'h000, 32'h0000_0102); wr(12'h240, 32'h100);
    rd(12'h100, v); repeat (60) @(posedge clk); #1; rd(12'h100, v2);
    chk("R2 P=2 D=1", 64'(v2 - v), 64'(ticks_in(60, 2, 1)));
    wr(12'h000, 32'h0000_0300);
    rd(12'h100, v); repeat (80) @(posedge clk); #1; rd(12'h100, v2);
    chk("R2 P=0 D=3", 64'(v2 - v), 64'(ticks_in(80, 0, 3)));
    wr(12'h000, 32'h0); wr(12'h240, 32'h0);
    rd(12'h100, v); repeat (5) @(posedge clk); #1; rd(12'h100, v2);
    chk("R3 stopped after clear", 64'(v2), 64'(v));

    // R4/R5 write and read back, clear acks first
    wr(12'h110, 32'h3); wr(12'h24C, 32'h1FFFF);
    wr(12'h100, 32'hFFFF_FFF0); wr(12'h104, 32'h0000_0001);
    rd64(12'h100, w); chk("R4 counter words", w, 64'h1_FFFF_FFF0);
    rd(12'h110, v); chk("R10 both counter acks", 64'(v), 64'h3);
    wr(12'h110, 32'h1); rd(12'h110, v); chk("R10 clear low ack", 64'(v), 64'h2);
    wr(12'h200, 32'h0000_0005); wr(12'h204, 32'h0000_0002); wr(12'h208, 32'd10);
    rd64(12'h200, w); chk("R5 channel 0 value", w, 64'h2_0000_0005);
    rd(12'h208, v); chk("R5 channel 0 increment", 64'(v), 64'd10);
    wr(12'h248, 32'h1); wr(12'h244, 32'hF);

    // R6/R7/R4 carry: match 21 steps later, repeat adds 10
    wr(12'h240, 32'h103);
    repeat (20) @(posedge clk); @(negedge clk);
    rd(12'h244, v); chk("R6 no match before value", 64'(v), 64'h0);
    @(posedge clk); @(negedge clk);
    rd(12'h244, v); chk("R6 match after carry", 64'(v), 64'h1);
    chk("R8 irq0 raised", 64'(irq), 64'h1);
    rd64(12'h200, w); chk("R7 first increment", w, 64'h2_0000_000F);
    repeat (10) @(posedge clk); @(negedge clk);
    rd64(12'h200, w); chk("R7 second increment", w, 64'h2_0000_0019);
    wr(12'h240, 32'h003);
    rd64(12'h100, w); chk("R4 carry into high word", w, 64'h2_0000_0010);

    // R8 gating and immediate raise, R9 clear
    wr(12'h248, 32'h0); chk("R8 irq off when disabled", 64'(irq), 64'h0);
    wr(12'h248, 32'h1); chk("R8 raise on enable while pending", 64'(irq), 64'h1);
    wr(12'h244, 32'h0); rd(12'h244, v); chk("R9 zero bits leave status", 64'(v), 64'h1);
    wr(12'h244, 32'h1); rd(12'h244, v); chk("R9 status cleared", 64'(v), 64'h0);
    chk("R9 irq dropped", 64'(irq), 64'h0);

    // R11 acknowledge bit positions
    wr(12'h24C, 32'h1FFFF);
    wr(ofs(1, 0), 32'h5); wr(ofs(1, 1), 32'h0); wr(ofs(2, 2), 32'h7); wr(12'h240, 32'h0);
    rd(12'h24C, v); chk("R11 ack bits", 64'(v), 64'h10430);
    wr(12'h24C, 32'h10); rd(12'h24C, v); chk("R11 selective clear", 64'(v), 64'h10420);

    // R12 unmapped offsets
    rd(12'h0F0, v); chk("R12 read hole 0x0F0", 64'(v), 64'h0);
    rd(12'h20C, v); chk("R12 read hole 0x20C", 64'(v), 64'h0);
    rd64(12'h100, w);
    wr(12'h0F0, 32'hFFFF_FFFF); wr(12'h20C, 32'hFFFF_FFFF); wr(12'h300, 32'hFFFF_FFFF);
    rd(12'h24C, v); chk("R12 ack untouched", 64'(v), 64'h10420);
    rd(12'h240, v); chk("R12 control untouched", 64'(v), 64'h0);
    rd64(12'h100, m_cnt); chk("R12 counter untouched", m_cnt, w);

    // R6/R7/R8 randomized rounds against the reference model
    for (int r = 0; r < 4; r++) begin
      m_cnt = {$urandom(), $urandom()};
      wr(12'h100, m_cnt[31:0]); wr(12'h104, m_cnt[63:32]);
      m_en = 4'($urandom()); m_auto = 4'($urandom());
      ctrl = 32'h100;
      for (int c = 0; c < NCH; c++) begin
        m_cmp[c] = m_cnt + 64'(1 + $urandom_range(0, 39));
        m_inc[c] = 32'(1 + $urandom_range(0, 29));
        wr(ofs(c, 0), m_cmp[c][31:0]); wr(ofs(c, 1), m_cmp[c][63:32]); wr(ofs(c, 2), m_inc[c]);
        ctrl[2*c] = m_en[c]; ctrl[2*c+1] = m_auto[c];
      end
      wr(12'h248, 32'hF); wr(12'h244, 32'hF);
      m_stat = '0;
      wr(12'h240, ctrl);
      mism = 0;
      for (int k = 0; k < 150; k++) begin
        @(posedge clk); model_step();
        @(negedge clk);
        if (irq !== m_stat) begin
          if (mism == 0) $display("FAIL R8 round %0d cycle %0d actual=%h expected=%h", r, k, irq, m_stat);
          mism++;
        end
      end
      checks++; if (mism != 0) errors++;
      wr(12'h240, 32'h0); model_step();
      for (int c = 0; c < NCH; c++) begin
        rd64(ofs(c, 0), w); chk("R7 model compare value", w, m_cmp[c]);
      end
      rd(12'h244, v); chk("R6 model status", 64'(v), 64'(m_stat));
      rd64(12'h100, w); chk("R3 model counter", w, m_cnt);
    end

    summary();
    $finish;
  end
endmodule